// File: doc/BRIEF.md
# Runtime Histogram Collector

This block watches a stream of signed random samples at full clock rate and keeps a count of how many samples fell into each of a set of equal-width bins. The bins are chosen by the top bits of each sample, so the bins tile the whole signed range in order, from the most negative bin to the most positive. With the default widths the samples are 16-bit two's complement values with four integer bits. The 512 bins then cover -8 to +8, each 1/32 wide.

Counting is a read-modify-write on a storage array and sustains one sample per cycle. Samples that land back to back in the same bin have their counts forwarded inside the pipeline, so no increment is lost. A separate read port lets a host fetch any bin's count while counting goes on, for example to form a goodness-of-fit statistic off-block. Counters stop at their largest value. A clear sequence walks every bin to zero, both after reset and on request. While it runs, `busy` is high and samples are ignored.

Top module: `hist_collector`

## Requirements
- R1: After reset `busy` is high while the clear sequence runs. Once `busy` falls, every bin reads zero.
- R2: The bin of a sample is its top BIN_W bits with the sign bit inverted. For 16-bit samples and 9-bit bins, 0x8000 goes to bin 0, 0xFF80 to bin 255, 0x0000 and 0x007F to bin 256, 0x0080 to bin 257, 0x4000 to bin 384 and 0x7FFF to bin 511.
- R3: Each cycle with `smp_valid` high and `busy` low adds exactly one to the addressed bin. A cycle with `smp_valid` low changes no bin.
- R4: Samples on consecutive cycles that hit the same bin, or that alternate between bins, are all counted. No increment is lost.
- R5: A bin that holds 2^CNT_W-1 stays at that value on further hits and never wraps.
- R6: A `clr_req` pulse while idle raises `busy` for exactly 2^BIN_W cycles and leaves every bin at zero. Samples presented while `busy` is high are not counted. A `clr_req` while `busy` is high neither restarts nor extends the sequence.
- R7: `rd_en` with `rd_addr` returns that bin's count on `rd_data` one cycle later, with `rd_valid` high only in that cycle. Host reads run in the same cycles as counting without disturbing it. A read in the same cycle as that bin's update returns the value before the update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed sample, two's complement |
| clr_req | input | 1 | Request to zero all bins |
| busy | output | 1 | Clear sequence in progress, samples ignored |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | BIN_W | Bin to read |
| rd_data | output | CNT_W | Count of the bin read in the previous cycle |
| rd_valid | output | 1 | `rd_data` holds a fresh read result |

## Verification
The counting path is driven with the following sample patterns:
- Repeated identical samples, which exercise the forwarding path.
- Samples at both range ends and either side of zero, which tell apart an inverted and a non-inverted sign bit in the bin index.
- Bins hit alternately, which separate a missed forward from a wrong forward.
- Strobe-low cycles carrying bin-aligned data, which show whether data is counted without its strobe.

A long run on one bin, with the counters narrowed to eight bits, separates saturation from wrap-around. A clear carried out under a stream of samples and a second request checks the ignore window and the fixed sequence length. A host read overlapping live counting shows the two ports do not interfere.

// File: rtl/hc_pkg.sv
package hc_pkg;

  // Operating mode of the bin-clearing walker.
  typedef enum logic {
    MODE_RUN   = 1'b0,
    MODE_CLEAR = 1'b1
  } hc_mode_e;

endpackage

// File: rtl/hc_rst_sync.sv
module hc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/hc_bin_map.sv
module hc_bin_map #(
  parameter int SAMPLE_W = 16,
  parameter int BIN_W    = 9
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic [BIN_W-1:0]    bin
);

  // Inverting the sign bit turns two's complement into offset binary,
  // so bin 0 is the most negative slice of the range.
  generate
    if (BIN_W == 1) begin : g_one_bin_bit
      assign bin = ~sample[SAMPLE_W-1];
    end else begin : g_multi_bin_bits
      assign bin = {~sample[SAMPLE_W-1], sample[SAMPLE_W-2 -: BIN_W-1]};
    end

    if (SAMPLE_W > BIN_W) begin : g_low_bits
      logic unused_low_bits;
      assign unused_low_bits = ^sample[SAMPLE_W-BIN_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/hc_clear_seq.sv
module hc_clear_seq
  import hc_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  hc_mode_e          mode_q, mode_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    mode_d = mode_q;
    addr_d = addr_q;
    if (mode_q == MODE_RUN) begin
      if (start) begin
        mode_d = MODE_CLEAR;
        addr_d = '0;
      end
    end else begin
      addr_d = addr_q + 1'b1;
      if (addr_q == LAST_ADDR) begin
        mode_d = MODE_RUN;
      end
    end
  end

  // Reset enters the clear walk so the array starts from zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_CLEAR;
      addr_q <= '0;
    end else begin
      mode_q <= mode_d;
      addr_q <= addr_d;
    end
  end

  assign busy    = (mode_q == MODE_CLEAR);
  assign wr_en   = busy;
  assign wr_addr = addr_q;

endmodule

// File: rtl/hc_count_ram.sv
module hc_count_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ra_en,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic              rb_en,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Both read ports return the contents before a same-edge write.
  always_ff @(posedge clk) begin
    if (ra_en) begin
      ra_data <= mem[ra_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rb_en) begin
      rb_data <= mem[rb_addr];
    end
  end

endmodule

// File: rtl/hist_collector.sv
module hist_collector #(
  parameter int SAMPLE_W = 16,
  parameter int BIN_W    = 9,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                clr_req,
  output logic                busy,
  input  logic                rd_en,
  input  logic [BIN_W-1:0]    rd_addr,
  output logic [CNT_W-1:0]    rd_data,
  output logic                rd_valid
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic rst_n_q;

  hc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_q)
  );

  // Clear walker
  logic             clr_busy;
  logic             clr_we;
  logic [BIN_W-1:0] clr_addr;
  logic             clr_start;

  assign clr_start = clr_req & ~clr_busy;

  hc_clear_seq #(.ADDR_W(BIN_W)) u_clear (
    .clk     (clk),
    .rst_n   (rst_n_q),
    .start   (clr_start),
    .busy    (clr_busy),
    .wr_en   (clr_we),
    .wr_addr (clr_addr)
  );

  // Stage 0: bin select and array read
  logic [BIN_W-1:0] smp_bin;
  logic             take;

  hc_bin_map #(.SAMPLE_W(SAMPLE_W), .BIN_W(BIN_W)) u_bin_map (
    .sample (smp_data),
    .bin    (smp_bin)
  );

  assign take = smp_valid & ~clr_busy;

  // Stage 1 registers (sample waiting on array data)
  logic             s1_vld_q, s1_vld_d;
  logic [BIN_W-1:0] s1_bin_q, s1_bin_d;

  // Stage 2 registers (last value written by the counting path)
  logic             s2_vld_q, s2_vld_d;
  logic [BIN_W-1:0] s2_bin_q, s2_bin_d;
  logic [CNT_W-1:0] s2_cnt_q, s2_cnt_d;

  logic             rd_valid_q, rd_valid_d;

  // Array wiring
  logic             ram_we;
  logic [BIN_W-1:0] ram_waddr;
  logic [CNT_W-1:0] ram_wdata;
  logic [CNT_W-1:0] ram_qa;

  hc_count_ram #(.ADDR_W(BIN_W), .DATA_W(CNT_W)) u_ram (
    .clk     (clk),
    .wr_en   (ram_we),
    .wr_addr (ram_waddr),
    .wr_data (ram_wdata),
    .ra_en   (take),
    .ra_addr (smp_bin),
    .ra_data (ram_qa),
    .rb_en   (rd_en),
    .rb_addr (rd_addr),
    .rb_data (rd_data)
  );

  // Stage 1 update: forward the previous write when it hit the same bin,
  // since the array read that fed this stage returned the value before it.
  logic             fwd_hit;
  logic [CNT_W-1:0] cnt_base;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_we;

  always_comb begin
    fwd_hit  = s2_vld_q && (s2_bin_q == s1_bin_q);
    cnt_base = fwd_hit ? s2_cnt_q : ram_qa;
    cnt_nxt  = (cnt_base == CNT_MAX) ? CNT_MAX : cnt_base + 1'b1;
    cnt_we   = s1_vld_q & ~clr_busy;
  end

  // The write port goes to the clear walker while it is active.
  always_comb begin
    ram_we    = clr_we | cnt_we;
    ram_waddr = clr_we ? clr_addr : s1_bin_q;
    ram_wdata = clr_we ? '0 : cnt_nxt;
  end

  // Next state of the pipeline registers
  always_comb begin
    s1_vld_d   = take;
    s1_bin_d   = take ? smp_bin : s1_bin_q;
    s2_vld_d   = cnt_we;
    s2_bin_d   = cnt_we ? s1_bin_q : s2_bin_q;
    s2_cnt_d   = cnt_we ? cnt_nxt : s2_cnt_q;
    rd_valid_d = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      s1_vld_q   <= 1'b0;
      s1_bin_q   <= '0;
      s2_vld_q   <= 1'b0;
      s2_bin_q   <= '0;
      s2_cnt_q   <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      s1_vld_q   <= s1_vld_d;
      s1_bin_q   <= s1_bin_d;
      s2_vld_q   <= s2_vld_d;
      s2_bin_q   <= s2_bin_d;
      s2_cnt_q   <= s2_cnt_d;
      rd_valid_q <= rd_valid_d;
    end
  end

  assign busy     = clr_busy;
  assign rd_valid = rd_valid_q;

endmodule

// File: rtl/hc_checker.sv
module hc_checker #(
  parameter int BIN_W = 9,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             smp_msb,
  input logic             busy,
  input logic             rd_en,
  input logic             rd_valid,
  input logic             cnt_we,
  input logic [BIN_W-1:0] cnt_bin,
  input logic [CNT_W-1:0] cnt_nxt
);

  localparam int               DEPTH   = 1 << BIN_W;
  localparam int               RUN_W   = BIN_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  // Length of the current busy stretch.
  logic [RUN_W-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run <= '0;
    end else if (busy) begin
      if (busy_run != RUN_MAX) busy_run <= busy_run + 1'b1;
    end else begin
      busy_run <= '0;
    end
  end

  // R2: bin MSB is the inverted sample sign
  a_r2_sign_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !busy) |=> (cnt_bin[BIN_W-1] == !$past(smp_msb)));

  // R4: a repeated bin on consecutive writes advances by one
  a_r4_forward_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we && $past(cnt_we) && (cnt_bin == $past(cnt_bin)) && ($past(cnt_nxt) != CNT_MAX))
      |-> (cnt_nxt == $past(cnt_nxt) + 1'b1));

  // R5: a counting write never stores zero
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |-> (cnt_nxt != '0));

  // R6: no counting write while busy
  a_r6_ignore_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cnt_we);

  // R6: a clear lasts one cycle per bin
  a_r6_clear_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == RUN_W'(DEPTH)));

  // R7: read result appears exactly one cycle after the strobe
  a_r7_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

endmodule

bind hist_collector hc_checker #(.BIN_W(BIN_W), .CNT_W(CNT_W)) u_hc_checker (
  .clk       (clk),
  .rst_n     (rst_n_q),
  .smp_valid (smp_valid),
  .smp_msb   (smp_data[SAMPLE_W-1]),
  .busy      (busy),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid),
  .cnt_we    (cnt_we),
  .cnt_bin   (s1_bin_q),
  .cnt_nxt   (cnt_nxt)
);

// File: tb/tb_hist_collector.sv
module tb_hist_collector;

  localparam int SW    = 16;
  localparam int BW    = 9;
  localparam int CW    = 8;
  localparam int DEPTH = 512;
  localparam int MAXC  = 255;

  typedef struct packed {
    logic [15:0] smp;
    logic [8:0]  bin;
    logic [7:0]  reps;
  } vec_t;

  // sample, expected bin (R2), back-to-back repeats
  localparam vec_t VECS [0:7] = '{
    '{16'h0000, 9'd256, 8'd3},
    '{16'h8000, 9'd0,   8'd1},
    '{16'h7FFF, 9'd511, 8'd2},
    '{16'hFF80, 9'd255, 8'd4},
    '{16'h0080, 9'd257, 8'd1},
    '{16'h007F, 9'd256, 8'd2},
    '{16'hC000, 9'd128, 8'd5},
    '{16'h4000, 9'd384, 8'd1}
  };

  logic          clk;
  logic          rst_n;
  logic          smp_valid;
  logic [SW-1:0] smp_data;
  logic          clr_req;
  logic          busy;
  logic          rd_en;
  logic [BW-1:0] rd_addr;
  logic [CW-1:0] rd_data;
  logic          rd_valid;

  int pass_n;
  int fail_n;
  int exp_cnt [DEPTH];

  hist_collector #(.SAMPLE_W(SW), .BIN_W(BW), .CNT_W(CW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .clr_req   (clr_req),
    .busy      (busy),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  initial clk = 1'b0;
  always #4ns clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int expv);
    if (act == expv) begin
      pass_n++;
    end else begin
      fail_n++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic model_add(input int b, input int n);
    exp_cnt[b] = (exp_cnt[b] + n > MAXC) ? MAXC : exp_cnt[b] + n;
  endtask

  // All tasks start and end just after a falling edge.
  task automatic send(input logic [SW-1:0] s);
    smp_valid = 1'b1;
    smp_data  = s;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    smp_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic read_bin(input int b, output int d, output int v);
    rd_en   = 1'b1;
    rd_addr = BW'(b);
    @(negedge clk);
    rd_en = 1'b0;
    d = int'(rd_data);
    v = int'(rd_valid);
  endtask

  task automatic check_bin(input string req, input int b);
    int d;
    int v;
    read_bin(b, d, v);
    chk(req, $sformatf("bin %0d count", b), d, exp_cnt[b]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fail_n++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end

  initial begin
    int d;
    int v;
    int n;
    pass_n = 0;
    fail_n = 0;
    for (int i = 0; i < DEPTH; i++) exp_cnt[i] = 0;
    rst_n     = 1'b0;
    smp_valid = 1'b0;
    smp_data  = '0;
    clr_req   = 1'b0;
    rd_en     = 1'b0;
    rd_addr   = '0;

    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1", "busy during reset", int'(busy), 1);
    chk("R1", "rd_valid during reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after release", int'(busy), 1);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk("R1", "busy fell after init clear", int'(busy), 0);
    check_bin("R1", 0);
    check_bin("R1", 256);
    check_bin("R1", 511);

    // R2 R3 R4: vector table, repeats exercise forwarding
    for (int i = 0; i < 8; i++) begin
      for (int r = 0; r < int'(VECS[i].reps); r++) send(VECS[i].smp);
      model_add(int'(VECS[i].bin), int'(VECS[i].reps));
      idle(3);
      check_bin("R2 R3 R4", int'(VECS[i].bin));
    end

    // R3: strobe low with bin-aligned data counts nothing
    smp_valid = 1'b0;
    smp_data  = 16'h0000;
    repeat (6) @(negedge clk);
    check_bin("R3", 256);

    // R4: alternating bins 128 and 384
    for (int i = 0; i < 7; i++) send((i % 2 == 0) ? 16'hC000 : 16'h4000);
    model_add(128, 4);
    model_add(384, 3);
    idle(3);
    check_bin("R4", 128);
    check_bin("R4", 384);

    // R7: host read overlapping live counting
    smp_valid = 1'b1;
    smp_data  = 16'h0000;
    rd_en     = 1'b1;
    rd_addr   = 9'd0;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R7", "rd_valid one cycle after strobe", int'(rd_valid), 1);
    chk("R7", "bin 0 read during counting", int'(rd_data), exp_cnt[0]);
    send(16'h0000);
    send(16'h0000);
    send(16'h0000);
    chk("R7", "rd_valid drops after read", int'(rd_valid), 0);
    model_add(256, 4);
    idle(3);
    check_bin("R7", 256);

    // R6: clear under a sample stream with a second request mid-way
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    n = 0;
    while (busy && n < 2000) begin
      n++;
      smp_valid = 1'b1;
      smp_data  = 16'h0000;
      clr_req   = (n == 100);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    clr_req   = 1'b0;
    chk("R6", "busy cycles of one clear", n, DEPTH);
    for (int i = 0; i < DEPTH; i++) exp_cnt[i] = 0;
    idle(3);
    check_bin("R6", 256);
    check_bin("R6", 128);
    check_bin("R6", 0);

    // R5: saturation on bin 320 (sample 0x2000)
    for (int i = 0; i < 300; i++) send(16'h2000);
    model_add(320, 300);
    idle(3);
    check_bin("R5", 320);
    send(16'h2000);
    model_add(320, 1);
    idle(3);
    check_bin("R5", 320);
    check_bin("R5", 319);

    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end

endmodule